// File: doc/BRIEF.md
# Dual-register serial programming interface

This block is the control front end of a frequency synthesizer. A host shifts words in, least significant bit first, over a serial clock pin and a serial data pin. A select pin decides where each bit goes. With the select low, bits go to a 20-bit frequency buffer. With it high, bits go to an 8-bit enhancement buffer. Each buffer has its own commit event. A rising edge on the commit pin copies the frequency buffer into the frequency register. A falling edge on the select pin copies the enhancement buffer into the enhancement register.

The frequency register holds the reference divide value (6 bits), the main divide value (9 bits), the swallow count (4 bits) and a prescaler bypass flag. These fields sit interleaved across the 20-bit word. A mode pin can replace the serial frequency word with parallel pins. When it does, bypass is forced off. The enhancement register provides power down, counter load and a test output mux. The mux puts one of three internal signals on a single output pin. An active-low enable pin gates the whole enhancement register.

All serial pins are sampled into the system clock domain through a synchronizer chain, and edges are found from the synchronized samples. The serial link is a plain pin interface with no valid/ready handshake. The block can always accept a bit, so it never applies back-pressure. The host must hold each level of the serial clock for at least SYNC_STAGES+1 system clock cycles. It must also set data and select before the serial clock edge that uses them.

Top module: `sprog_top`

## Requirements
- R1: After reset, with serial mode selected and the enhancement enable low, all divider fields, `bypass`, `pwr_down`, `cnt_load` and `dout` read 0.
- R2: While `ser_sel` is low, each rising `ser_clk` edge shifts `ser_dat` into the frequency buffer. The first bit lands at word bit 0 after 20 shifts. The decoded fields do not change until a rising edge of `ser_commit`, which copies the whole buffer at once.
- R3: Frequency word map, by bit index of the 20-bit word:
  - bit0..bit1 hold `r_div[5:4]`, with bit0 = `r_div[5]`.
  - bits 12..15 hold `r_div[3:0]`, with bit12 = `r_div[3]`.
  - bits 2, 3 hold `m_div[8]`, `m_div[7]`.
  - bit 4 holds `bypass`.
  - bits 5..11 hold `m_div[6:0]`, with bit5 = `m_div[6]`.
  - bits 16..19 hold `a_cnt[3:0]`, with bit16 = `a_cnt[3]`.
- R4: While `ser_sel` is high, each rising `ser_clk` edge shifts a bit into the 8-bit enhancement buffer. The enhancement register takes the buffer only on a falling edge of `ser_sel`. Loading the enhancement register leaves the frequency fields unchanged.
- R5: Enhancement bit 3 drives `pwr_down` and bit 4 drives `cnt_load`, both active high. Both outputs read 0 whenever `enh_n` is high.
- R6: `dout` follows the enhancement select bits with priority bit 2 (`fp_in`), then bit 5 (`msel_in`), then bit 6 (`fc_in`). It reads 0 when no select bit is set or when `enh_n` is high.
- R7: With `dmode` high, the fields come from `dir_r`, `dir_m` and `dir_a`, and `bypass` reads 0 whatever the frequency register holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dmode | input | 1 | 1 selects parallel pin fields, 0 serial register fields |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_dat | input | 1 | Serial data, LSB first |
| ser_commit | input | 1 | Rising edge commits the frequency buffer |
| ser_sel | input | 1 | 1 routes bits to the enhancement buffer; falling edge commits it |
| enh_n | input | 1 | Active-low enable of enhancement functions |
| dir_r | input | 6 | Parallel reference divide value |
| dir_m | input | 9 | Parallel main divide value |
| dir_a | input | 4 | Parallel swallow count |
| fp_in | input | 1 | Main divider output for the test mux |
| fc_in | input | 1 | Reference divider output for the test mux |
| msel_in | input | 1 | Modulus select for the test mux |
| r_div | output | 6 | Reference divide value |
| m_div | output | 9 | Main divide value |
| a_cnt | output | 4 | Swallow count |
| bypass | output | 1 | Prescaler bypass |
| pwr_down | output | 1 | Power down request |
| cnt_load | output | 1 | Continuous counter load request |
| dout | output | 1 | Test mux output |

## Verification
The bench builds the block with SYNC_STAGES=3. A longer chain delays every serial pin by one more cycle. This checks that the data, select and commit pins stay aligned with the serial clock edge through the whole chain. The bench holds each serial level for six cycles, which is just above the minimum for that depth. This setting therefore exercises the edge ordering between the select line and the serial clock close to its limit.

// File: rtl/sprog_pkg.sv
package sprog_pkg;
  localparam int FREQ_W = 20;
  localparam int ENH_W  = 8;
  localparam int R_W    = 6;
  localparam int M_W    = 9;
  localparam int A_W    = 4;
  localparam int PB_BIT = 4;
  localparam int FP_SEL = 2;
  localparam int PD_BIT = 3;
  localparam int CL_BIT = 4;
  localparam int MS_SEL = 5;
  localparam int FC_SEL = 6;

  typedef struct packed {
    logic [R_W-1:0] r;
    logic [M_W-1:0] m;
    logic [A_W-1:0] a;
    logic           pb;
  } freq_fields_t;
endpackage

// File: rtl/sprog_sync.sv
module sprog_sync #(
  parameter int N      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q,
  output logic [N-1:0] q_prev
);
  for (genvar i = 0; i < N; i++) begin : g_pin
    logic [STAGES:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-1:0], d[i]};
    end
    assign q[i]      = chain[STAGES-1];
    assign q_prev[i] = chain[STAGES];
  end
endmodule

// File: rtl/sprog_shift.sv
module sprog_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift,
  input  logic         din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (shift) q <= {din, q[W-1:1]};
  end
endmodule

// File: rtl/sprog_decode.sv
module sprog_decode
  import sprog_pkg::*;
(
  input  logic              dmode,
  input  logic              enh_n,
  input  logic [FREQ_W-1:0] fword,
  input  logic [ENH_W-1:0]  eword,
  input  logic [R_W-1:0]    dir_r,
  input  logic [M_W-1:0]    dir_m,
  input  logic [A_W-1:0]    dir_a,
  input  logic              fp_in,
  input  logic              fc_in,
  input  logic              msel_in,
  output freq_fields_t      fields,
  output logic              pwr_down,
  output logic              cnt_load,
  output logic              dout
);
  freq_fields_t ser_f;
  logic         en;
  logic         unused_reserved;

  assign unused_reserved = ^{eword[7], eword[1:0]};

  always_comb begin
    ser_f.r  = {fword[0], fword[1], fword[12], fword[13], fword[14], fword[15]};
    ser_f.m  = {fword[2], fword[3], fword[5], fword[6], fword[7], fword[8],
                fword[9], fword[10], fword[11]};
    ser_f.a  = {fword[16], fword[17], fword[18], fword[19]};
    ser_f.pb = fword[PB_BIT];
  end

  always_comb begin
    if (dmode) begin
      fields.r  = dir_r;
      fields.m  = dir_m;
      fields.a  = dir_a;
      fields.pb = 1'b0;
    end else begin
      fields = ser_f;
    end
  end

  assign en       = !enh_n;
  assign pwr_down = en & eword[PD_BIT];
  assign cnt_load = en & eword[CL_BIT];

  always_comb begin
    dout = 1'b0;
    if (en) begin
      if (eword[FP_SEL])      dout = fp_in;
      else if (eword[MS_SEL]) dout = msel_in;
      else if (eword[FC_SEL]) dout = fc_in;
    end
  end

  always_comb begin
    if (dmode) begin
      a_r7_no_bypass: assert (!fields.pb);
    end
    if (enh_n) begin
      a_r5_gated: assert (!pwr_down && !cnt_load);
      a_r6_dout_off: assert (!dout);
    end
  end
endmodule

// File: rtl/sprog_top.sv
module sprog_top
  import sprog_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           dmode,
  input  logic           ser_clk,
  input  logic           ser_dat,
  input  logic           ser_commit,
  input  logic           ser_sel,
  input  logic           enh_n,
  input  logic [R_W-1:0] dir_r,
  input  logic [M_W-1:0] dir_m,
  input  logic [A_W-1:0] dir_a,
  input  logic           fp_in,
  input  logic           fc_in,
  input  logic           msel_in,
  output logic [R_W-1:0] r_div,
  output logic [M_W-1:0] m_div,
  output logic [A_W-1:0] a_cnt,
  output logic           bypass,
  output logic           pwr_down,
  output logic           cnt_load,
  output logic           dout
);
  localparam int NPIN = 4;
  localparam int P_CLK = 0, P_DAT = 1, P_CMT = 2, P_SEL = 3;

  logic [NPIN-1:0] s_q, s_prev;
  logic            unused_dat_prev;
  logic            clk_rise, f_shift, e_shift, f_commit, e_commit;
  logic [FREQ_W-1:0] f_buf, f_reg;
  logic [ENH_W-1:0]  e_buf, e_reg;
  freq_fields_t      fields;

  sprog_sync #(.N(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({ser_sel, ser_commit, ser_dat, ser_clk}),
    .q(s_q), .q_prev(s_prev)
  );

  assign unused_dat_prev = s_prev[P_DAT];
  assign clk_rise = s_q[P_CLK] & ~s_prev[P_CLK];
  assign f_shift  = clk_rise & ~s_q[P_SEL];
  assign e_shift  = clk_rise &  s_q[P_SEL];
  assign f_commit = s_q[P_CMT] & ~s_prev[P_CMT];
  assign e_commit = ~s_q[P_SEL] & s_prev[P_SEL];

  sprog_shift #(.W(FREQ_W)) u_fbuf (
    .clk(clk), .rst_n(rst_n), .shift(f_shift), .din(s_q[P_DAT]), .q(f_buf)
  );
  sprog_shift #(.W(ENH_W)) u_ebuf (
    .clk(clk), .rst_n(rst_n), .shift(e_shift), .din(s_q[P_DAT]), .q(e_buf)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_reg <= '0;
      e_reg <= '0;
    end else begin
      if (f_commit) f_reg <= f_buf;
      if (e_commit) e_reg <= e_buf;
    end
  end

  a_r2_freq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !f_commit |=> $stable(f_reg));
  a_r4_enh_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !e_commit |=> $stable(e_reg));
  a_r4_one_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({f_shift, e_shift}));

  sprog_decode u_dec (
    .dmode(dmode), .enh_n(enh_n), .fword(f_reg), .eword(e_reg),
    .dir_r(dir_r), .dir_m(dir_m), .dir_a(dir_a),
    .fp_in(fp_in), .fc_in(fc_in), .msel_in(msel_in),
    .fields(fields), .pwr_down(pwr_down), .cnt_load(cnt_load), .dout(dout)
  );

  assign r_div  = fields.r;
  assign m_div  = fields.m;
  assign a_cnt  = fields.a;
  assign bypass = fields.pb;
endmodule

// File: tb/tb_sprog_top.sv
module tb_sprog_top;
  logic clk = 0, rst_n = 0;
  logic dmode = 0, ser_clk = 0, ser_dat = 0, ser_commit = 0, ser_sel = 0, enh_n = 0;
  logic [5:0] dir_r = 0;
  logic [8:0] dir_m = 0;
  logic [3:0] dir_a = 0;
  logic fp_in = 0, fc_in = 0, msel_in = 0;
  logic [5:0] r_div;
  logic [8:0] m_div;
  logic [3:0] a_cnt;
  logic bypass, pwr_down, cnt_load, dout;
  int total = 0, bad = 0;
  bit done = 0;
  localparam int HOLD = 6;

  always #4 clk = ~clk;

  sprog_top #(.SYNC_STAGES(3)) dut (
    .clk(clk), .rst_n(rst_n), .dmode(dmode), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .ser_commit(ser_commit), .ser_sel(ser_sel), .enh_n(enh_n),
    .dir_r(dir_r), .dir_m(dir_m), .dir_a(dir_a),
    .fp_in(fp_in), .fc_in(fc_in), .msel_in(msel_in),
    .r_div(r_div), .m_div(m_div), .a_cnt(a_cnt), .bypass(bypass),
    .pwr_down(pwr_down), .cnt_load(cnt_load), .dout(dout)
  );

  localparam logic [27:0] VEC [6] = '{
    {20'h00001, 8'h08}, {20'hFFFFF, 8'h10}, {20'h0F0F0, 8'h04},
    {20'hA5C3E, 8'h00}, {20'h00010, 8'h18}, {20'h5A5A5, 8'h24}
  };

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic send_bit(logic b);
    ser_dat = b; tick(HOLD);
    ser_clk = 1; tick(HOLD);
    ser_clk = 0; tick(HOLD);
  endtask

  task automatic shift_freq(logic [19:0] w);
    ser_sel = 0; tick(HOLD);
    for (int i = 0; i < 20; i++) send_bit(w[i]);
  endtask

  task automatic commit_freq();
    ser_commit = 1; tick(HOLD);
    ser_commit = 0; tick(HOLD);
  endtask

  task automatic shift_enh(logic [7:0] w);
    ser_sel = 1; tick(HOLD);
    for (int i = 0; i < 8; i++) send_bit(w[i]);
  endtask

  task automatic load_enh(logic [7:0] w);
    shift_enh(w);
    ser_sel = 0; tick(HOLD);
  endtask

  function automatic logic [19:0] exp_fields(logic [19:0] w);
    logic [5:0] r; logic [8:0] m; logic [3:0] a;
    r = {w[0], w[1], w[12], w[13], w[14], w[15]};
    m = {w[2], w[3], w[5], w[6], w[7], w[8], w[9], w[10], w[11]};
    a = {w[16], w[17], w[18], w[19]};
    return {r, m, a, w[4]};
  endfunction

  function automatic logic exp_dout(logic [7:0] e);
    if (enh_n) return 0;
    if (e[2]) return fp_in;
    if (e[5]) return msel_in;
    if (e[6]) return fc_in;
    return 0;
  endfunction

  task automatic chk_fields(string req, logic [19:0] w);
    logic [19:0] x;
    x = exp_fields(w);
    chk({req, " r_div"}, int'(r_div), int'(x[19:14]));
    chk({req, " m_div"}, int'(m_div), int'(x[13:5]));
    chk({req, " a_cnt"}, int'(a_cnt), int'(x[4:1]));
    chk({req, " bypass"}, int'(bypass), int'(x[0]));
  endtask

  initial begin
    fp_in = 1; fc_in = 1; msel_in = 1;
    tick(3); rst_n = 1; tick(2);
    // R1 reset state
    chk("R1 r_div", int'(r_div), 0);
    chk("R1 m_div", int'(m_div), 0);
    chk("R1 a_cnt", int'(a_cnt), 0);
    chk("R1 bypass", int'(bypass), 0);
    chk("R1 pwr_down", int'(pwr_down), 0);
    chk("R1 cnt_load", int'(cnt_load), 0);
    chk("R1 dout", int'(dout), 0);

    fp_in = 1; msel_in = 0; fc_in = 1;
    for (int v = 0; v < 6; v++) begin
      shift_freq(VEC[v][27:8]);
      commit_freq();
      load_enh(VEC[v][7:0]);
      chk_fields("R3 R4", VEC[v][27:8]);
      chk("R5 pwr_down", int'(pwr_down), int'(VEC[v][3]));
      chk("R5 cnt_load", int'(cnt_load), int'(VEC[v][4]));
      chk("R6 dout", int'(dout), int'(exp_dout(VEC[v][7:0])));
    end

    // R2: shifting without commit leaves fields untouched
    shift_freq(20'h00010);
    chk_fields("R2 no-commit", 20'h5A5A5);
    commit_freq();
    chk_fields("R2 commit", 20'h00010);

    // R4: enhancement register waits for falling select
    shift_enh(8'h08);
    chk("R4 before fall", int'(pwr_down), 0);
    ser_sel = 0; tick(HOLD);
    chk("R4 after fall", int'(pwr_down), 1);
    chk_fields("R4 freq kept", 20'h00010);

    // R5 gating
    enh_n = 1; tick(1);
    chk("R5 gated pwr_down", int'(pwr_down), 0);
    enh_n = 0;

    // R6 priority
    load_enh(8'h64);
    fp_in = 1; msel_in = 0; fc_in = 0; tick(1);
    chk("R6 fp first hi", int'(dout), 1);
    fp_in = 0; msel_in = 1; fc_in = 1; tick(1);
    chk("R6 fp first lo", int'(dout), 0);
    enh_n = 1; fp_in = 1; tick(1);
    chk("R6 gated", int'(dout), 0);
    enh_n = 0;
    load_enh(8'h60);
    msel_in = 1; fc_in = 0; tick(1);
    chk("R6 msel over fc hi", int'(dout), 1);
    msel_in = 0; fc_in = 1; tick(1);
    chk("R6 msel over fc lo", int'(dout), 0);
    load_enh(8'h40);
    fc_in = 1; tick(1);
    chk("R6 fc hi", int'(dout), 1);
    fc_in = 0; tick(1);
    chk("R6 fc lo", int'(dout), 0);
    load_enh(8'h00);
    fp_in = 1; msel_in = 1; fc_in = 1; tick(1);
    chk("R6 none", int'(dout), 0);

    // R7 direct mode, register holds PB=1
    dir_r = 6'h2A; dir_m = 9'h155; dir_a = 4'h9; dmode = 1; tick(1);
    chk("R7 r_div", int'(r_div), 'h2A);
    chk("R7 m_div", int'(m_div), 'h155);
    chk("R7 a_cnt", int'(a_cnt), 'h9);
    chk("R7 bypass", int'(bypass), 0);
    dmode = 0; tick(1);
    chk("R7 back to serial", int'(bypass), 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired got=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule